// File: doc/BRIEF.md
# LCD Frame Rate Tick Generator

This block sets the frame rate of a segment LCD controller from a slow clock. It divides in two stages. The first stage is a power-of-two prescaler. The second is a small integer divider. The block emits a one-cycle enable pulse in the slow-clock domain. It does not build a derived clock. Downstream waveform logic uses the pulse to advance its frame timing.

Both division settings live in one configuration word on a simple register bus. A write that is accepted lands in a shadow copy, which reads back at once. The running copy takes the shadow value only on a frame-start pulse, and at that moment both counters restart. Software can therefore change the rate at any time without producing a torn frame. Two lock inputs block writes: a write-protection enable and a frozen-state flag. A write attempted while either lock is high raises a one-cycle error pulse.

The interface carries only control and status, and it has no data stream. For that reason it has no valid/ready handshake. Every pin is a plain level or a plain pulse.

Top module: `lcd_frame_clkgen`

## Requirements
- R1: After reset the shadow and running settings are both zero, the config word reads 0, and `rate_tick` pulses once every 8 slow-clock cycles.
- R2: The config word sits at offset 0x08. The prescale code is in bits 2:0 and the divide code is in bits 10:8. All other bits read as 0. A read at any other offset returns 0. Reads are combinational from the address.
- R3: Prescale code n divides the slow clock by 2^(n+3), giving a range of /8 to /1024.
- R4: Divide code m further divides by m+1. The tick period is therefore 2^(n+3)·(m+1) cycles.
- R5: `rate_tick` is high for exactly one cycle per period.
- R6: An accepted write updates the readable shadow from the next cycle on, but it does not change the tick period.
- R7: When `frame_start` is high at a clock edge, the running settings take the shadow value held before that edge and both counters restart. The first tick is then seen in the P·D-th cycle after that edge, where P and D are the new division values.
- R8: A write while `wr_protect` is high leaves the shadow and running settings unchanged.
- R9: A write while `cfg_frozen` is high leaves the shadow and running settings unchanged.
- R10: `lock_err` is high for the one cycle after a write to offset 0x08 that was attempted while either lock was high. Otherwise it is low.
- R11: A write to any offset other than 0x08 changes no setting and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| wr_protect | input | 1 | Write-protection enable; blocks writes when high |
| cfg_frozen | input | 1 | Frozen-state flag; blocks writes when high |
| frame_start | input | 1 | Frame boundary pulse; applies the shadow settings |
| rate_tick | output | 1 | One-cycle frame-rate enable pulse |
| lock_err | output | 1 | One-cycle pulse after a locked write attempt |

## Verification
The bench uses the default parameters: 3-bit codes, an 8-bit address and a 32-bit word. At these sizes every one of the 64 prescale/divide pairs can be exercised, including the longest 8192-cycle period, within the run budget. A behavioural model counts the cycles since the last frame boundary and predicts the tick, the read data and the error pulse on every cycle. Directed phases cover a change made without a frame boundary, writes to the wrong offset, and writes under each of the two locks.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int CODE_W   = 3;
  localparam int PRE_BASE = 3;                               // smallest prescale is 2^PRE_BASE
  localparam int PCNT_W   = PRE_BASE + (1 << CODE_W) - 1;    // holds 2^(max code+PRE_BASE)-1
  localparam int PRESC_LSB = 0;
  localparam int DIV_LSB   = 8;

  typedef struct packed {
    logic [CODE_W-1:0] div;
    logic [CODE_W-1:0] presc;
  } rate_cfg_t;
endpackage

// File: rtl/lfc_regs.sv
module lfc_regs
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_OFF = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp_lock,
  input  logic              frz_lock,
  input  logic              frame_start,
  output rate_cfg_t         active_q,
  output logic [DATA_W-1:0] rdata,
  output logic              lock_err_q
);
  rate_cfg_t shadow_q;
  logic hit, locked, accept;

  assign hit    = we && (addr == CFG_OFF);
  assign locked = wp_lock || frz_lock;
  assign accept = hit && !locked;

  wire unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      active_q   <= '0;
      lock_err_q <= 1'b0;
    end else begin
      lock_err_q <= hit && locked;
      if (frame_start) active_q <= shadow_q;
      if (accept) begin
        shadow_q.presc <= wdata[PRESC_LSB +: CODE_W];
        shadow_q.div   <= wdata[DIV_LSB +: CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CFG_OFF) begin
      rdata[PRESC_LSB +: CODE_W] = shadow_q.presc;
      rdata[DIV_LSB +: CODE_W]   = shadow_q.div;
    end
  end

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q));
  // R8
  locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err_q |-> $stable(shadow_q));
  // R11
  other_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != CFG_OFF) |=> ($stable(shadow_q) && !lock_err_q));
endmodule

// File: rtl/lfc_prescaler.sv
module lfc_prescaler
  import lfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              pre_tick
);
  logic [PCNT_W-1:0] pcnt, lim;

  always_comb lim = PCNT_W'((32'd1 << (32'(code) + PRE_BASE)) - 32'd1);
  assign pre_tick = (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (restart)  pcnt <= '0;
    else if (pre_tick) pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end

  // R3
  pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= lim);
endmodule

// File: rtl/lfc_divider.sv
module lfc_divider
  import lfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_tick,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CODE_W-1:0] dcnt;

  assign tick = pre_tick && (dcnt == code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dcnt <= '0;
    else if (restart)  dcnt <= '0;
    else if (pre_tick) dcnt <= (dcnt == code) ? '0 : dcnt + 1'b1;
  end

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= code);
endmodule

// File: rtl/lcd_frame_clkgen.sv
module lcd_frame_clkgen
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_OFF = 8'h08
) (
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wr_protect,
  input  logic              cfg_frozen,
  input  logic              frame_start,
  output logic              rate_tick,
  output logic              lock_err
);
  rate_cfg_t active;
  logic pre_tick;

  lfc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFF(CFG_OFF)) u_regs (
    .clk(clk_slow), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .wp_lock(wr_protect), .frz_lock(cfg_frozen), .frame_start(frame_start),
    .active_q(active), .rdata(reg_rdata), .lock_err_q(lock_err));

  lfc_prescaler u_pre (
    .clk(clk_slow), .rst_n(rst_n), .restart(frame_start),
    .code(active.presc), .pre_tick(pre_tick));

  lfc_divider u_div (
    .clk(clk_slow), .rst_n(rst_n), .restart(frame_start), .pre_tick(pre_tick),
    .code(active.div), .tick(rate_tick));

  // R5
  tick_single_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    rate_tick |=> !rate_tick);
  // R10
  err_single_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    lock_err |=> !lock_err);
endmodule

// File: tb/sim_lcd_frame_clkgen.sv
module sim_lcd_frame_clkgen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h08;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wp = 1'b0, frz = 1'b0, fs = 1'b0;
  logic        tick, err;

  lcd_frame_clkgen u0 (
    .clk_slow(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .wr_protect(wp), .cfg_frozen(frz), .frame_start(fs),
    .rate_tick(tick), .lock_err(err));

  int n_chk = 0, n_fail = 0, ticks_seen = 0;
  int sh_p = 0, sh_d = 0, ac_p = 0, ac_d = 0, m_cnt = 0;
  bit m_err = 0;
  string tag = "R1";

  function automatic int period(int p, int d);
    return (1 << (p + 3)) * (d + 1);
  endfunction

  task automatic chk(string r, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // reference model, advanced on each edge
  always @(posedge clk) begin
    bit hit, lk;
    if (!rst_n) begin
      sh_p = 0; sh_d = 0; ac_p = 0; ac_d = 0; m_cnt = 0; m_err = 0;
    end else begin
      hit = we && addr == 8'h08;
      lk  = wp || frz;
      m_err = hit && lk;
      if (fs) begin ac_p = sh_p; ac_d = sh_d; m_cnt = 0; end
      else m_cnt++;
      if (hit && !lk) begin sh_p = int'(wdata[2:0]); sh_d = int'(wdata[10:8]); end
    end
  end

  always @(negedge clk) if (rst_n) begin
    int per;
    per = period(ac_p, ac_d);
    chk(tag, "rate_tick", tick, (m_cnt % per) == per - 1);
    chk("R10", "lock_err", err, m_err);
    chk("R2", "reg_rdata", rdata, (addr == 8'h08) ? ((sh_d << 8) | sh_p) : 0);
    if (tick) ticks_seen++;
  end

  task automatic step();
    @(posedge clk); #2;
  endtask
  task automatic idle(int n);
    repeat (n) step();
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(); addr = a; we = 1'b1; wdata = d;
    step(); we = 1'b0; addr = 8'h08;
  endtask
  task automatic fstart();
    step(); fs = 1'b1;
    step(); fs = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    tag = "R1";
    @(negedge clk); chk("R1", "reset read", rdata, 0);
    ticks_seen = 0; idle(32);
    chk("R1", "ticks in 32 cycles", ticks_seen, 4);

    tag = "R2";
    wr(8'h08, 32'hFFFF_FFFF);
    @(negedge clk); chk("R2", "masked read", rdata, 32'h0707);
    step(); addr = 8'h0C; @(negedge clk); chk("R2", "other offset read", rdata, 0);
    step(); addr = 8'h08;

    tag = "R6";
    wr(8'h08, 32'h0000_0201);
    @(negedge clk); chk("R6", "shadow read", rdata, 32'h0201);
    ticks_seen = 0; idle(40);
    chk("R6", "period still 8", ticks_seen, 5);

    tag = "R7";
    fstart(); ticks_seen = 0; idle(48);
    chk("R7", "first tick after 48", ticks_seen, 1);
    idle(48);

    tag = "R11";
    wr(8'h0C, 32'h0000_0305);
    @(negedge clk); chk("R11", "shadow kept", rdata, 32'h0201);
    idle(60);

    tag = "R8";
    wp = 1'b1; wr(8'h08, 32'h0); wp = 1'b0;
    @(negedge clk); chk("R8", "shadow kept", rdata, 32'h0201);
    fstart(); ticks_seen = 0; idle(96);
    chk("R8", "period still 48", ticks_seen, 2);

    tag = "R9";
    frz = 1'b1; wr(8'h08, 32'h0); frz = 1'b0;
    @(negedge clk); chk("R9", "shadow kept", rdata, 32'h0201);
    fstart(); ticks_seen = 0; idle(96);
    chk("R9", "period still 48", ticks_seen, 2);

    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 8; d++) begin
        tag = "R3";
        wr(8'h08, 32'((d << 8) | p));
        fstart(); ticks_seen = 0;
        idle(period(p, d) + 2);
        chk("R4", $sformatf("one tick p=%0d d=%0d", p, d), ticks_seen, 1);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule